// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block works out the two upcoming program-counter values for a processor that has one branch delay slot. Each cycle it takes a branch instruction's fields and the current PC, next PC and next-next PC. It registers the updated next PC and next-next PC. It also registers a squash flag that tells the pipeline to discard the delay-slot instruction.

Two instruction formats are accepted. The long format has a 22-bit word displacement and the short format has a 19-bit one. The displacement is sign-extended, turned into a byte offset, and added to the branch's own PC.

The two unconditional encodings are decoded on their own paths, each with its own annul behaviour:
- "always" (condition 8)
- "never" (condition 0)

The other fourteen conditions are tested against the integer condition codes. A failed test with the annul bit set skips the delay slot.

Top module: `branch_pc_seq`

## Requirements
- R1: While `rst_n` is low, `npc_o`, `nnpc_o` and `squash_o` are all zero.
- R2: Outputs are registered. Values presented at the inputs appear at the outputs after the next rising clock edge, and not before it.
- R3: The branch target is `pc_i` plus the sign-extended displacement times 4, modulo 2^AW. When `fmt_short_i`=0 the displacement is all 22 bits of `disp_i`. When `fmt_short_i`=1 it is `disp_i[18:0]`, and bits 21:19 are ignored.
- R4: With condition 8 and annul clear, next PC is unchanged, next-next PC becomes the target, and no squash is raised.
- R5: With condition 8 and annul set, next PC becomes the target, next-next PC becomes target+4, and squash is raised.
- R6: With condition 0 and annul clear, both next PC and next-next PC pass through unchanged and squash stays low.
- R7: With condition 0 and annul set, next PC becomes old next PC+4, next-next PC becomes old next PC+8, and squash is raised.
- R8: `icc_i` is {N,Z,V,C} from bit 3 down to bit 0. The conditions other than 0 and 8 evaluate as follows:
  - 1 = Z
  - 2 = Z|(N^V)
  - 3 = N^V
  - 4 = C|Z
  - 5 = C
  - 6 = N
  - 7 = V
  - 9..15 are the complements of 1..7 in the same order.
- R9: A generic condition that passes keeps next PC, sets next-next PC to the target, and keeps squash low, whatever the annul bit.
- R10: A generic condition that fails with annul clear leaves next PC and next-next PC unchanged.
- R11: A generic condition that fails with annul set gives next PC = old next PC+4 and next-next PC = old next PC+8, and raises squash.
- R12: Squash is raised only in the R5, R7 and R11 cases. Whenever it is raised, next-next PC equals next PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_short_i | input | 1 | 1 selects the 19-bit displacement format |
| cond_i | input | 4 | Branch condition field |
| annul_i | input | 1 | Annul bit of the branch |
| disp_i | input | 22 | Word displacement field |
| icc_i | input | 4 | Integer condition codes {N,Z,V,C} |
| pc_i | input | AW | PC of the branch instruction |
| npc_i | input | AW | Current next PC |
| nnpc_i | input | AW | Current next-next PC |
| npc_o | output | AW | Updated next PC |
| nnpc_o | output | AW | Updated next-next PC |
| squash_o | output | 1 | Discard the delay-slot instruction |

## Verification
The bench builds the block with its default widths: a 32-bit PC and displacement fields of 22 and 19 bits. At these widths it can sweep every combination of format, condition, annul bit and condition codes, with random addresses. It can also reach the boundary cases:
- PC wraparound at 2^32.
- The largest and most negative displacement in each format.
- Junk in the upper displacement bits of the short format.

// File: rtl/branch_pc_seq.sv
module branch_pc_seq #(
  parameter int AW      = 32,
  parameter int LONG_W  = 22,
  parameter int SHORT_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_short_i,
  input  logic [3:0]        cond_i,
  input  logic              annul_i,
  input  logic [LONG_W-1:0] disp_i,
  input  logic [3:0]        icc_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     npc_i,
  input  logic [AW-1:0]     nnpc_i,
  output logic [AW-1:0]     npc_o,
  output logic [AW-1:0]     nnpc_o,
  output logic              squash_o
);

  localparam logic [3:0]    COND_NEVER  = 4'h0;
  localparam logic [3:0]    COND_ALWAYS = 4'h8;
  localparam logic [AW-1:0] STEP        = AW'(4);

  logic n, z, v, c;
  assign {n, z, v, c} = icc_i;

  logic signed [LONG_W-1:0]  d_long;
  logic signed [SHORT_W-1:0] d_short;
  logic [AW-1:0]             offset, target, skip_npc;

  assign d_long   = disp_i;
  assign d_short  = disp_i[SHORT_W-1:0];
  assign offset   = (fmt_short_i ? AW'(d_short) : AW'(d_long)) << 2;
  assign target   = pc_i + offset;
  assign skip_npc = npc_i + STEP;

  logic base, pass;
  always_comb begin
    case (cond_i[2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = z;
      3'd2:    base = z | (n ^ v);
      3'd3:    base = n ^ v;
      3'd4:    base = c | z;
      3'd5:    base = c;
      3'd6:    base = n;
      default: base = v;
    endcase
  end
  assign pass = base ^ cond_i[3];

  logic          is_always, is_never;
  logic [AW-1:0] nxt_npc, nxt_nnpc;
  logic          nxt_sq;

  assign is_always = (cond_i == COND_ALWAYS);
  assign is_never  = (cond_i == COND_NEVER);

  always_comb begin
    nxt_npc  = npc_i;
    nxt_nnpc = nnpc_i;
    nxt_sq   = 1'b0;
    if (is_always) begin
      if (annul_i) begin
        nxt_npc  = target;
        nxt_nnpc = target + STEP;
        nxt_sq   = 1'b1;
      end else begin
        nxt_nnpc = target;
      end
    end else if (is_never || !pass) begin
      if (annul_i) begin
        nxt_npc  = skip_npc;
        nxt_nnpc = skip_npc + STEP;
        nxt_sq   = 1'b1;
      end
    end else begin
      nxt_nnpc = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_o    <= '0;
      nnpc_o   <= '0;
      squash_o <= 1'b0;
    end else begin
      npc_o    <= nxt_npc;
      nnpc_o   <= nxt_nnpc;
      squash_o <= nxt_sq;
    end
  end

endmodule

// File: rtl/branch_pc_seq_chk.sv
module branch_pc_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cond_i,
  input logic          annul_i,
  input logic [AW-1:0] npc_i,
  input logic [AW-1:0] nnpc_i,
  input logic [AW-1:0] npc_o,
  input logic [AW-1:0] nnpc_o,
  input logic          squash_o
);

  localparam logic [AW-1:0] STEP = AW'(4);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (npc_o == '0 && nnpc_o == '0 && !squash_o);
    end
  end

  p_skip_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> nnpc_o == npc_o + STEP);

  p_no_annul_no_squash_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !annul_i) |-> !squash_o);

  p_keep_npc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !squash_o) |-> npc_o == $past(npc_i));

  p_never_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && cond_i == 4'h0 && !annul_i) |->
      (nnpc_o == $past(nnpc_i) && !squash_o));

  p_always_annul_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && cond_i == 4'h8 && annul_i) |-> squash_o);

endmodule

bind branch_pc_seq branch_pc_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .annul_i(annul_i),
  .npc_i(npc_i), .nnpc_i(nnpc_i),
  .npc_o(npc_o), .nnpc_o(nnpc_o), .squash_o(squash_o)
);

// File: tb/tb_branch_pc_seq.sv
`timescale 1ns/1ps
module tb_branch_pc_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fmt_short_i;
  logic [3:0]  cond_i;
  logic        annul_i;
  logic [21:0] disp_i;
  logic [3:0]  icc_i;
  logic [31:0] pc_i, npc_i, nnpc_i;
  logic [31:0] npc_o, nnpc_o;
  logic        squash_o;

  always #10 clk = ~clk;

  branch_pc_seq dut (
    .clk(clk), .rst_n(rst_n), .fmt_short_i(fmt_short_i), .cond_i(cond_i),
    .annul_i(annul_i), .disp_i(disp_i), .icc_i(icc_i), .pc_i(pc_i),
    .npc_i(npc_i), .nnpc_i(nnpc_i), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .squash_o(squash_o)
  );

  int checks = 0;
  int failures = 0;

  logic        have_exp = 1'b0;
  logic [31:0] e_npc, e_nnpc;
  logic        e_sq;
  string       e_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_cond(input logic [3:0] cd, input logic [3:0] cc);
    bit n, z, v, c;
    {n, z, v, c} = cc;
    case (cd)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return c | z;
      4'd5:  return c;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(c | z);
      4'd13: return !c;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  task automatic model();
    longint sd;
    logic [31:0] tgt;
    if (fmt_short_i) sd = longint'($signed(disp_i[18:0]));
    else             sd = longint'($signed(disp_i));
    tgt = pc_i + 32'(sd * 4);
    e_npc = npc_i; e_nnpc = nnpc_i; e_sq = 1'b0;
    if (cond_i == 4'd8) begin
      if (annul_i) begin e_npc = tgt; e_nnpc = tgt + 4; e_sq = 1'b1; e_tag = "R5/R3"; end
      else begin e_nnpc = tgt; e_tag = "R4/R3"; end
    end else if (cond_i == 4'd0) begin
      if (annul_i) begin e_npc = npc_i + 4; e_nnpc = npc_i + 8; e_sq = 1'b1; e_tag = "R7"; end
      else e_tag = "R6";
    end else if (ref_cond(cond_i, icc_i)) begin
      e_nnpc = tgt; e_tag = "R9/R8/R3";
    end else if (annul_i) begin
      e_npc = npc_i + 4; e_nnpc = npc_i + 8; e_sq = 1'b1; e_tag = "R11/R8";
    end else e_tag = "R10/R8";
  endtask

  task automatic compare_pending();
    if (have_exp) begin
      check(npc_o === e_npc, e_tag, "npc", npc_o, e_npc);
      check(nnpc_o === e_nnpc, e_tag, "nnpc", nnpc_o, e_nnpc);
      check(squash_o === e_sq, "R12", "squash", 32'(squash_o), 32'(e_sq));
    end
  endtask

  task automatic apply(input logic f, input logic [3:0] cd, input logic a,
                       input logic [21:0] d, input logic [3:0] cc,
                       input logic [31:0] pc, input logic [31:0] np,
                       input logic [31:0] nnp);
    logic [31:0] held;
    @(negedge clk);
    compare_pending();
    held = npc_o;
    fmt_short_i = f; cond_i = cd; annul_i = a; disp_i = d; icc_i = cc;
    pc_i = pc; npc_i = np; nnpc_i = nnp;
    #2;
    check(npc_o === held, "R2", "npc before edge", npc_o, held);
    model();
    have_exp = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt_short_i = 1'b0; cond_i = '0; annul_i = 1'b0;
    disp_i = '0; icc_i = '0; pc_i = '0; npc_i = '0; nnpc_i = '0;
    pc_i = 32'h1234_5678; npc_i = 32'hABCD_0000; nnpc_i = 32'h5555_AAAA;
    cond_i = 4'd8; annul_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(npc_o === 32'h0 && nnpc_o === 32'h0 && squash_o === 1'b0,
            "R1", "reset outputs", npc_o | nnpc_o | 32'(squash_o), 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int f = 0; f < 2; f++)
      for (int cd = 0; cd < 16; cd++)
        for (int a = 0; a < 2; a++)
          for (int cc = 0; cc < 16; cc++) begin
            logic [31:0] pc;
            pc = $urandom();
            apply(f[0], cd[3:0], a[0], 22'($urandom()), cc[3:0],
                  pc, $urandom(), $urandom());
          end

    // R3 boundaries: sign extension, junk upper bits, wraparound
    apply(1'b0, 4'd8, 1'b0, 22'h1F_FFFF, 4'h0, 32'h0000_1000, 32'h0, 32'h0);
    apply(1'b0, 4'd8, 1'b1, 22'h20_0000, 4'h0, 32'h0000_1000, 32'h4, 32'h8);
    apply(1'b1, 4'd8, 1'b0, 22'h3B_FFFF, 4'h0, 32'h0000_2000, 32'h0, 32'h0);
    apply(1'b1, 4'd8, 1'b1, 22'h04_0000, 4'h0, 32'h0000_2000, 32'h0, 32'h0);
    apply(1'b0, 4'd8, 1'b1, 22'h00_0004, 4'h0, 32'hFFFF_FFF0, 32'h0, 32'h0);
    apply(1'b1, 4'd8, 1'b0, 22'h3F_FFFF, 4'h0, 32'h0000_0000, 32'h0, 32'h0);
    apply(1'b0, 4'd1, 1'b0, 22'h00_0010, 4'h4, 32'hFFFF_FFFC, 32'h0, 32'h0);
    // R7/R11: next PC wraps when skipping the delay slot
    apply(1'b0, 4'd0, 1'b1, 22'h0, 4'h0, 32'h0, 32'hFFFF_FFFC, 32'h0);
    apply(1'b1, 4'd1, 1'b1, 22'h0, 4'h0, 32'h0, 32'hFFFF_FFF8, 32'h0);
    @(negedge clk);
    compare_pending();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule